// File: doc/BRIEF.md
# SWD Host Transaction Engine

This block performs one complete Serial Wire Debug transaction from the host side. A single `start` pulse captures a 4-bit request, the 32-bit write word and three configuration inputs. The block then generates SWCLK and drives SWDIO through a separate output enable while it sends the 8-bit request header, turns the line around and samples the target's 3-bit acknowledge. After that it moves data, performs dummy phases or backs off, depending on the acknowledge. When it finishes it pulses `done` and presents a 4-bit status and, after a successful read, the captured word.

The request is `req[0]` = access-port select, `req[1]` = read (1) or write (0), and `req[3:2]` = register address bits. Each bit slot lasts `2*HALF_PERIOD` system clocks. SWCLK is low for the first half of a slot and high for the second half. New output values appear at the start of the slot, and SWDIO is sampled on the system clock edge just before SWCLK rises. Retry policy and register meaning belong to the layer above.

The control FSM has these states: ST_IDLE, ST_HDR, ST_TRN_A, ST_ACK, ST_RDAT, ST_TRN_B, ST_WDAT, ST_DUMMY, ST_BACKOFF and ST_IDLECYC. Its transitions are:
- ST_IDLE goes to ST_HDR on `start`.
- ST_HDR goes to ST_TRN_A after 8 slots.
- ST_TRN_A goes to ST_ACK after the turnaround slots.
- ST_ACK goes to one of four states after 3 slots: ST_RDAT for an OK read, ST_TRN_B for an OK write, ST_DUMMY for a WAIT or FAULT read with the data-phase option set, ST_TRN_B for any other WAIT or FAULT, and ST_BACKOFF for an invalid acknowledge.
- ST_RDAT goes to ST_TRN_B after 33 slots.
- ST_TRN_B goes to ST_WDAT for an OK write. For an OK read it goes to ST_IDLECYC, or to ST_IDLE when the idle count is 0. For a WAIT or FAULT write with the option set it goes to ST_DUMMY. Otherwise it goes to ST_IDLE.
- ST_WDAT goes to ST_IDLECYC, or to ST_IDLE when the idle count is 0.
- ST_DUMMY goes to ST_TRN_B on a read and to ST_IDLE on a write.
- ST_BACKOFF goes to ST_IDLE.
- ST_IDLECYC goes to ST_IDLE.

Top module: `swd_txn_engine`

## Requirements
- R1: The header is driven (output enable high) as 8 slots in this order: 1, req[0], req[1], req[2], req[3], even parity of req[3:0], 0, 1.
- R2: After the header, SWDIO is released for `trn_cfg+1` slots. Then 3 acknowledge bits are sampled LSB first. The acknowledge codes are OK=3'b001, WAIT=3'b010 and FAULT=3'b100. For these codes and for invalid codes, `status` = {1'b0, ack}.
- R3: On an OK read, the line stays released while 32 data bits are sampled LSB first, then one parity bit, then `trn_cfg+1` turnaround slots. `rdata` then holds the sampled word.
- R4: On an OK read whose parity bit differs from the even parity of the 32 data bits, `status` is 4'b1000.
- R5: On an OK write, `trn_cfg+1` released slots come first. Then 32 driven bits of `wdata` follow LSB first, then their even-parity bit.
- R6: After an OK transfer, SWDIO is driven low for `idle_cfg` slots, with no slots when `idle_cfg` is 0. When the block is not busy, SWDIO is driven high.
- R7: On WAIT or FAULT with `data_phase_en` set, a read gives 33 released slots and then the turnaround. A write gives the turnaround and then 33 slots driven low.
- R8: On WAIT or FAULT with `data_phase_en` clear, only the turnaround slots follow the acknowledge.
- R9: On an invalid acknowledge, `trn_cfg+1+33` released slots follow, and the raw code is returned.
- R10: SWCLK is high whenever the block is not busy. SWDIO and its enable never change on a rising SWCLK edge. `done` is a single-cycle pulse at which `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transaction (accepted when not busy) |
| req | input | 4 | {addr[3:2], read, access-port select} |
| wdata | input | 32 | Word to write |
| trn_cfg | input | 2 | Turnaround length minus one |
| idle_cfg | input | 8 | Idle slots after an OK transfer |
| data_phase_en | input | 1 | Run dummy data phase on WAIT/FAULT |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 4 | Acknowledge code, or 4'b1000 on read parity error |
| rdata | output | 32 | Word captured by the last OK read |
| swclk | output | 1 | Serial clock to target |
| swdio_out | output | 1 | Serial data driven by host |
| swdio_oe | output | 1 | Output enable for swdio_out |
| swdio_in | input | 1 | Serial data from target |

## Verification
The assertions check four things on every cycle: the line is driven high and the clock is parked high outside a transaction, output never moves on a rising clock edge, the line is released during turnaround, acknowledge and read data, and the driven-low level holds through the idle cycles. Only the bench's scenarios can show the remaining behaviour, because it depends on what the target returns: the exact slot sequence for each acknowledge outcome, the ordering of dummy phases against turnaround, the parity-error status and the captured read word. The bench compares the full per-slot trace of the line against a trace it builds from the request.

// File: rtl/swd_txn_pkg.sv
package swd_txn_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HDR,
        ST_TRN_A,
        ST_ACK,
        ST_RDAT,
        ST_TRN_B,
        ST_WDAT,
        ST_DUMMY,
        ST_BACKOFF,
        ST_IDLECYC
    } swd_state_e;

    localparam logic [2:0] ACK_OK    = 3'b001;
    localparam logic [2:0] ACK_WAIT  = 3'b010;
    localparam logic [2:0] ACK_FAULT = 3'b100;

    localparam logic [3:0] STAT_PARERR = 4'b1000;

    localparam int HDR_BITS = 8;
    localparam int ACK_BITS = 3;

endpackage

// File: rtl/swd_slot_timer.sv
module swd_slot_timer #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic swclk,
    output logic rise,
    output logic slot_end
);
    localparam int SLOT = 2 * HALF;
    localparam int PH_W = (SLOT > 2) ? $clog2(SLOT) : 1;

    logic [PH_W-1:0] ph;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph <= '0;
        end else if (!run || ph == PH_W'(SLOT - 1)) begin
            ph <= '0;
        end else begin
            ph <= ph + 1'b1;
        end
    end

    assign swclk    = run ? (ph >= PH_W'(HALF)) : 1'b1;
    assign rise     = run && (ph == PH_W'(HALF - 1));
    assign slot_end = run && (ph == PH_W'(SLOT - 1));

endmodule

// File: rtl/swd_rx_capture.sv
module swd_rx_capture #(
    parameter int DATA_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            sample,
    input  logic            ack_en,
    input  logic            data_en,
    input  logic            din,
    output logic [2:0]      ack,
    output logic [DATA_W:0] frame
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack   <= '0;
            frame <= '0;
        end else if (clr) begin
            ack   <= '0;
            frame <= '0;
        end else if (sample) begin
            if (ack_en) begin
                ack <= {din, ack[2:1]};
            end
            if (data_en) begin
                frame <= {din, frame[DATA_W:1]};
            end
        end
    end

endmodule

// File: rtl/swd_txn_engine.sv
module swd_txn_engine
    import swd_txn_pkg::*;
#(
    parameter int HALF_PERIOD = 2,
    parameter int DATA_W      = 32,
    parameter int TRN_W       = 2,
    parameter int IDLE_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [3:0]        req,
    input  logic [DATA_W-1:0] wdata,
    input  logic [TRN_W-1:0]  trn_cfg,
    input  logic [IDLE_W-1:0] idle_cfg,
    input  logic              data_phase_en,
    output logic              busy,
    output logic              done,
    output logic [3:0]        status,
    output logic [DATA_W-1:0] rdata,
    output logic              swclk,
    output logic              swdio_out,
    output logic              swdio_oe,
    input  logic              swdio_in
);
    localparam int TRN_MAX  = 1 << TRN_W;
    localparam int LONGEST  = TRN_MAX + DATA_W + 1;
    localparam int IDLE_MAX = 1 << IDLE_W;
    localparam int CNT_W    = $clog2((LONGEST > IDLE_MAX ? LONGEST : IDLE_MAX) + 1);
    localparam int WIDX_W   = $clog2(DATA_W + 1);
    localparam int HIDX_W   = $clog2(HDR_BITS);

    typedef logic [CNT_W-1:0] cnt_t;

    swd_state_e        state, state_n;
    cnt_t              cnt, cnt_n;
    logic              finish;
    logic [3:0]        req_q;
    logic [DATA_W-1:0] wdata_q;
    logic [TRN_W-1:0]  trn_q;
    logic [IDLE_W-1:0] idle_q;
    logic              dp_q;
    logic              rise, slot_end, last;
    logic [2:0]        ack_cap;
    logic [DATA_W:0]   frame_cap;
    logic              is_read, ack_ok, ack_hold, par_bad;
    cnt_t              trn_last, data_last, back_last;
    logic [HDR_BITS-1:0] hdr_frame;
    logic [DATA_W:0]   wframe;
    logic [HIDX_W-1:0] hidx;
    logic [WIDX_W-1:0] widx;

    assign busy = (state != ST_IDLE);

    swd_slot_timer #(.HALF(HALF_PERIOD)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .swclk    (swclk),
        .rise     (rise),
        .slot_end (slot_end)
    );

    swd_rx_capture #(.DATA_W(DATA_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (state == ST_IDLE && start),
        .sample  (rise),
        .ack_en  (state == ST_ACK),
        .data_en (state == ST_RDAT),
        .din     (swdio_in),
        .ack     (ack_cap),
        .frame   (frame_cap)
    );

    assign is_read   = req_q[1];
    assign ack_ok    = (ack_cap == ACK_OK);
    assign ack_hold  = (ack_cap == ACK_WAIT) || (ack_cap == ACK_FAULT);
    assign par_bad   = (^frame_cap[DATA_W-1:0]) != frame_cap[DATA_W];
    assign trn_last  = cnt_t'(trn_q);
    assign data_last = cnt_t'(DATA_W);
    assign back_last = cnt_t'(trn_q) + cnt_t'(DATA_W + 1);
    assign last      = slot_end && (cnt == '0);

    // Next-state logic
    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        finish  = 1'b0;
        if (state != ST_IDLE && slot_end && cnt != '0) begin
            cnt_n = cnt - 1'b1;
        end
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    state_n = ST_HDR;
                    cnt_n   = cnt_t'(HDR_BITS - 1);
                end
            end
            ST_HDR: begin
                if (last) begin
                    state_n = ST_TRN_A;
                    cnt_n   = trn_last;
                end
            end
            ST_TRN_A: begin
                if (last) begin
                    state_n = ST_ACK;
                    cnt_n   = cnt_t'(ACK_BITS - 1);
                end
            end
            ST_ACK: begin
                if (last) begin
                    if (ack_ok && is_read) begin
                        state_n = ST_RDAT;
                        cnt_n   = data_last;
                    end else if (ack_ok) begin
                        state_n = ST_TRN_B;
                        cnt_n   = trn_last;
                    end else if (ack_hold && is_read && dp_q) begin
                        state_n = ST_DUMMY;
                        cnt_n   = data_last;
                    end else if (ack_hold) begin
                        state_n = ST_TRN_B;
                        cnt_n   = trn_last;
                    end else begin
                        state_n = ST_BACKOFF;
                        cnt_n   = back_last;
                    end
                end
            end
            ST_RDAT: begin
                if (last) begin
                    state_n = ST_TRN_B;
                    cnt_n   = trn_last;
                end
            end
            ST_TRN_B: begin
                if (last) begin
                    if (ack_ok && !is_read) begin
                        state_n = ST_WDAT;
                        cnt_n   = data_last;
                    end else if (ack_ok && idle_q != '0) begin
                        state_n = ST_IDLECYC;
                        cnt_n   = cnt_t'(idle_q) - 1'b1;
                    end else if (!ack_ok && !is_read && dp_q) begin
                        state_n = ST_DUMMY;
                        cnt_n   = data_last;
                    end else begin
                        state_n = ST_IDLE;
                        finish  = 1'b1;
                    end
                end
            end
            ST_WDAT: begin
                if (last) begin
                    if (idle_q != '0) begin
                        state_n = ST_IDLECYC;
                        cnt_n   = cnt_t'(idle_q) - 1'b1;
                    end else begin
                        state_n = ST_IDLE;
                        finish  = 1'b1;
                    end
                end
            end
            ST_DUMMY: begin
                if (last) begin
                    if (is_read) begin
                        state_n = ST_TRN_B;
                        cnt_n   = trn_last;
                    end else begin
                        state_n = ST_IDLE;
                        finish  = 1'b1;
                    end
                end
            end
            ST_BACKOFF, ST_IDLECYC: begin
                if (last) begin
                    state_n = ST_IDLE;
                    finish  = 1'b1;
                end
            end
            default: begin
                state_n = ST_IDLE;
            end
        endcase
    end

    // State and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            req_q   <= '0;
            wdata_q <= '0;
            trn_q   <= '0;
            idle_q  <= '0;
            dp_q    <= 1'b0;
            status  <= '0;
            rdata   <= '0;
            done    <= 1'b0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
            done  <= finish;
            if (state == ST_IDLE && start) begin
                req_q   <= req;
                wdata_q <= wdata;
                trn_q   <= trn_cfg;
                idle_q  <= idle_cfg;
                dp_q    <= data_phase_en;
            end
            if (finish) begin
                if (ack_ok && is_read && par_bad) begin
                    status <= STAT_PARERR;
                end else begin
                    status <= {1'b0, ack_cap};
                end
                if (ack_ok && is_read) begin
                    rdata <= frame_cap[DATA_W-1:0];
                end
            end
        end
    end

    // Line outputs
    assign hdr_frame = {1'b1, 1'b0, ^req_q, req_q[3], req_q[2], req_q[1], req_q[0], 1'b1};
    assign wframe    = {^wdata_q, wdata_q};
    assign hidx      = HIDX_W'(HDR_BITS - 1) - cnt[HIDX_W-1:0];
    assign widx      = WIDX_W'(data_last - cnt);

    always_comb begin
        swdio_oe  = 1'b1;
        swdio_out = 1'b1;
        unique case (state)
            ST_HDR: begin
                swdio_out = hdr_frame[hidx];
            end
            ST_TRN_A, ST_ACK, ST_RDAT, ST_TRN_B, ST_BACKOFF: begin
                swdio_oe = 1'b0;
            end
            ST_WDAT: begin
                swdio_out = wframe[widx];
            end
            ST_DUMMY: begin
                swdio_oe  = !is_read;
                swdio_out = is_read;
            end
            ST_IDLECYC: begin
                swdio_out = 1'b0;
            end
            default: begin
                swdio_oe  = 1'b1;
                swdio_out = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/swd_txn_checker.sv
module swd_txn_checker
    import swd_txn_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       done,
    input logic [3:0] status,
    input logic       swclk,
    input logic       swdio_out,
    input logic       swdio_oe,
    input swd_state_e state
);
    // R10
    idle_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (swclk && swdio_oe && swdio_out));

    // R10
    stable_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(swclk) |-> ($stable(swdio_out) && $stable(swdio_oe)));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy ##1 !done));

    // R2
    released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TRN_A || state == ST_ACK || state == ST_RDAT || state == ST_TRN_B)
        |-> !swdio_oe);

    // R1
    header_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HDR) |-> swdio_oe);

    // R6
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLECYC) |-> (swdio_oe && !swdio_out));

    // R4
    status_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status[3]) |-> (status[2:0] == 3'b000));

endmodule

bind swd_txn_engine swd_txn_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .status    (status),
    .swclk     (swclk),
    .swdio_out (swdio_out),
    .swdio_oe  (swdio_oe),
    .state     (state)
);

// File: tb/swd_txn_engine_bench.sv
module swd_txn_engine_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  req = '0;
    logic [31:0] wdata = '0;
    logic [1:0]  trn_cfg = '0;
    logic [7:0]  idle_cfg = '0;
    logic        data_phase_en = 1'b0;
    logic        busy, done, swclk, swdio_out, swdio_oe;
    logic [3:0]  status;
    logic [31:0] rdata;
    logic        swdio_in = 1'b1;

    swd_txn_engine u_swd_txn_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .req(req), .wdata(wdata),
        .trn_cfg(trn_cfg), .idle_cfg(idle_cfg), .data_phase_en(data_phase_en),
        .busy(busy), .done(done), .status(status), .rdata(rdata),
        .swclk(swclk), .swdio_out(swdio_out), .swdio_oe(swdio_oe),
        .swdio_in(swdio_in)
    );

    always #5 clk = ~clk;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;

    always @(posedge clk) begin
        cycles++;
        if (cycles >= 200000) begin
            n_fail++;
            $display("FAIL watchdog: actual cycles=%0d expected <200000", cycles);
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Target model state
    int          t_trn;
    logic [2:0]  t_ack;
    logic [31:0] t_rd;
    bit          t_corrupt, t_read, tracing = 1'b0;
    int          nedge;
    logic        tr_oe [0:255];
    logic        tr_out[0:255];
    logic        ex_oe [0:255];
    logic        ex_out[0:255];
    int          ex_n;

    function automatic logic drv(input int k);
        if (k >= 8 + t_trn && k < 11 + t_trn) return t_ack[k - 8 - t_trn];
        if (t_ack == 3'b001 && t_read && k >= 11 + t_trn && k < 43 + t_trn) return t_rd[k - 11 - t_trn];
        if (t_ack == 3'b001 && t_read && k == 43 + t_trn) return (^t_rd) ^ t_corrupt;
        return 1'b1;
    endfunction

    always @(posedge swclk) begin
        if (tracing) begin
            if (nedge < 256) begin
                tr_oe[nedge]  = swdio_oe;
                tr_out[nedge] = swdio_out;
            end
            nedge++;
            swdio_in <= #1 drv(nedge);
        end
    end

    task automatic push(input logic oe, input logic v);
        if (ex_n < 256) begin
            ex_oe[ex_n]  = oe;
            ex_out[ex_n] = v;
        end
        ex_n++;
    endtask

    task automatic build_exp(input logic [3:0] rq, input logic [31:0] wd, input int trn,
                             input int idl, input bit dp, input logic [2:0] ack);
        logic [7:0] h;
        ex_n = 0;
        h = {1'b1, 1'b0, ^rq, rq[3], rq[2], rq[1], rq[0], 1'b1};
        for (int i = 0; i < 8; i++) push(1'b1, h[i]);
        for (int i = 0; i < trn + 3; i++) push(1'b0, 1'b1);
        if (ack == 3'b001) begin
            if (rq[1]) begin
                for (int i = 0; i < 33 + trn; i++) push(1'b0, 1'b1);
            end else begin
                for (int i = 0; i < trn; i++) push(1'b0, 1'b1);
                for (int i = 0; i < 32; i++) push(1'b1, wd[i]);
                push(1'b1, ^wd);
            end
            for (int i = 0; i < idl; i++) push(1'b1, 1'b0);
        end else if (ack == 3'b010 || ack == 3'b100) begin
            if (rq[1]) begin
                if (dp) for (int i = 0; i < 33; i++) push(1'b0, 1'b1);
                for (int i = 0; i < trn; i++) push(1'b0, 1'b1);
            end else begin
                for (int i = 0; i < trn; i++) push(1'b0, 1'b1);
                if (dp) for (int i = 0; i < 33; i++) push(1'b1, 1'b0);
            end
        end else begin
            for (int i = 0; i < trn + 33; i++) push(1'b0, 1'b1);
        end
    endtask

    task automatic run_txn(input logic [3:0] rq, input logic [31:0] wd, input logic [1:0] trn,
                           input logic [7:0] idl, input bit dp, input logic [2:0] ack,
                           input logic [31:0] rd, input bit corrupt);
        string scen;
        int    w, bad;
        logic [3:0] exp_st;
        t_trn = int'(trn) + 1;
        t_ack = ack;
        t_rd = rd;
        t_corrupt = corrupt;
        t_read = rq[1];
        build_exp(rq, wd, t_trn, int'(idl), dp, ack);
        if (ack == 3'b001 && rq[1]) scen = corrupt ? "R4" : "R3";
        else if (ack == 3'b001) scen = "R5";
        else if (ack == 3'b010 || ack == 3'b100) scen = dp ? "R7" : "R8";
        else scen = "R9";
        if (ack == 3'b001 && idl != 0) scen = {scen, " R6"};
        exp_st = (ack == 3'b001 && rq[1] && corrupt) ? 4'b1000 : {1'b0, ack};
        nedge = 0;
        swdio_in = 1'b1;
        tracing = 1'b1;
        @(negedge clk);
        req = rq; wdata = wd; trn_cfg = trn; idle_cfg = idl; data_phase_en = dp;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        w = 0;
        while (!done && w < 2000) begin
            @(negedge clk);
            w++;
        end
        tracing = 1'b0;
        chk(done == 1'b1, {"R10 done ", scen}, 64'(done), 64'd1);
        chk(nedge == ex_n, {"R2 slot count ", scen}, 64'(nedge), 64'(ex_n));
        bad = -1;
        for (int i = 0; i < ex_n && i < 256 && i < nedge; i++) begin
            if (bad < 0 && (tr_oe[i] !== ex_oe[i] || (ex_oe[i] && tr_out[i] !== ex_out[i]))) bad = i;
        end
        if (bad >= 0)
            chk(1'b0, {"R1 R2 trace ", scen}, {32'(bad), 30'd0, tr_oe[bad], tr_out[bad]},
                {32'(bad), 30'd0, ex_oe[bad], ex_out[bad]});
        else
            chk(1'b1, {"R1 R2 trace ", scen}, 64'd0, 64'd0);
        chk(status == exp_st, {"R2 status ", scen}, 64'(status), 64'(exp_st));
        if (ack == 3'b001 && rq[1])
            chk(rdata == rd, "R3 rdata", 64'(rdata), 64'(rd));
        @(negedge clk);
        chk(!busy && swclk && swdio_oe && swdio_out && !done, "R6 R10 parked high",
            {60'd0, busy, swclk, swdio_oe, swdio_out}, 64'h7);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && swclk && swdio_oe && swdio_out && status == 4'd0,
            "R10 reset state", {59'd0, busy, done, swclk, swdio_oe, swdio_out}, 64'h7);

        // Directed corner cases
        run_txn(4'b0110, 32'h0, 2'd0, 8'd0, 1'b0, 3'b001, 32'hA5C3_0F81, 1'b0); // R3 read
        run_txn(4'b1011, 32'h0, 2'd3, 8'd2, 1'b0, 3'b001, 32'h1234_5678, 1'b1); // R4 parity error
        run_txn(4'b0000, 32'hDEAD_BEEF, 2'd1, 8'd0, 1'b0, 3'b001, 32'h0, 1'b0); // R5 idle 0
        run_txn(4'b1101, 32'h8000_0001, 2'd0, 8'd5, 1'b0, 3'b001, 32'h0, 1'b0); // R5 R6
        run_txn(4'b0010, 32'h0, 2'd1, 8'd0, 1'b1, 3'b010, 32'h0, 1'b0);         // R7 read
        run_txn(4'b0100, 32'hFFFF_FFFF, 2'd2, 8'd3, 1'b1, 3'b100, 32'h0, 1'b0); // R7 write
        run_txn(4'b0011, 32'h0, 2'd0, 8'd4, 1'b0, 3'b100, 32'h0, 1'b0);         // R8 read
        run_txn(4'b1000, 32'h5, 2'd3, 8'd0, 1'b0, 3'b010, 32'h0, 1'b0);         // R8 write
        run_txn(4'b0110, 32'h0, 2'd1, 8'd1, 1'b1, 3'b111, 32'h0, 1'b0);         // R9 all ones
        run_txn(4'b0001, 32'h0, 2'd0, 8'd0, 1'b0, 3'b000, 32'h0, 1'b0);         // R9 no response
        run_txn(4'b1111, 32'h0, 2'd3, 8'd0, 1'b0, 3'b001, 32'h0000_0000, 1'b0); // R3 zero word

        // Constrained random
        void'($urandom(32'd2024));
        for (int n = 0; n < 200; n++) begin
            logic [2:0] a;
            int sel;
            sel = int'($urandom_range(0, 7));
            if (sel < 4) a = 3'b001;
            else if (sel == 4) a = 3'b010;
            else if (sel == 5) a = 3'b100;
            else a = 3'($urandom);
            run_txn(4'($urandom), $urandom, 2'($urandom), 8'($urandom_range(0, 7)),
                    1'($urandom), a, $urandom, ($urandom_range(0, 5) == 0));
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule